// File: doc/BRIEF.md
# Serial Test-Bus Command Port

This block is a slave on a serial test and maintenance bus. A bus master frames each transfer with an active-low select, drives a 16-bit word least significant bit first on the serial input, and finishes with an odd parity bit. While the command comes in, the port sends back the response that the previous command produced, in the same format: 16 bits LSB first, then odd parity. The master drops select after the sixteenth data bit, and the parity bit is latched at that same point. That release makes the port run the command it has just received. All inputs are latched on the falling edge of the test clock.

A mode input, latched together with select at the start of a frame, chooses between command frames and scan frames. In a scan frame the serial data only passes through a short placeholder shift chain; no command runs. The command decode is a stub. It supports echo, a status read, and a read and a write of an 8-bit register file in the chip through a simple address/data port. A parity mismatch or a badly framed transfer sets a sticky status bit and pulls the active-low interrupt low. The bad command does not run.

Top module: `tbp_port`

## Requirements
- R1: A frame starts on the falling edge where sel_ni is first sampled low. The following 16 falling edges latch sdi_i as command bits 0 to 15, LSB first.
- R2: In a command frame, sdo_o carries bit i of the response register during the clock period that ends at the edge latching command bit i. During the period ending at the parity edge it carries the odd parity of the response (17 bits with an odd number of ones). After reset the response register is zero.
- R3: When select is high at the edge after the sixteenth bit, sdi_i is taken as the parity bit. If the parity is odd, exec_o is high for exactly one clock period after that edge, and cmd_o holds the received command.
- R4: On a parity mismatch no command runs (exec_o stays low, the response register is unchanged), status bit 0 sets and stays set, and irq_no goes low.
- R5: A select release before sixteen bits, or a seventeenth edge with select still low, sets status bit 1 and runs no command.
- R6: irq_no is low exactly while any status bit is set. After reset it is high.
- R7: Opcode (command bits 15:12) 1 is echo: the response equals the command.
- R8: Opcode 2 reads status: the response is {14'b0, bit1 framing error, bit0 parity error}, with the values held before that edge.
- R9: Opcode 3 writes register reg_addr_o = command bits 11:8 with reg_wdata_o = bits 7:0. reg_we_o pulses together with exec_o, and the response is the command.
- R10: Opcode 4 reads a register: the response is {command bits 15:8, reg_rdata_i sampled at the parity edge}, with reg_addr_o = command bits 11:8.
- R11: Opcode 5 clears status and its response is the command. Any other opcode still pulses exec_o, gives response 0 and has no other effect.
- R12: mode_i high at the frame start makes a scan frame. sdo_o shows the bit that entered SCAN_LEN (default 8) data edges earlier, with the chain starting at zero after reset and kept across frames. No command runs, and the response and status registers are unchanged.
- R13: A new frame may start on the edge right after a parity edge, while exec_o and reg_we_o of the previous command are still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock; inputs latched on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_ni | input | 1 | Active-low frame select |
| mode_i | input | 1 | 0 command frame, 1 scan frame |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| irq_no | output | 1 | Active-low interrupt, error status pending |
| exec_o | output | 1 | One-cycle execute strobe toward the chip |
| cmd_o | output | 16 | Last executed command |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 4 | Register address, command bits 11:8 |
| reg_wdata_o | output | 8 | Register write data, command bits 7:0 |
| reg_rdata_i | input | 8 | Register read data from the chip |

## Verification
The two functions that can share a cycle are the register write strobe of one command and the start of the next frame. They meet when the master pulls select low again on the edge right after a parity edge. The bench runs a write and then, back to back, a read of the same address. It checks that the strobe and address show up while the new frame starts, that the new frame streams out the write's response, and that the frame after it returns the written byte.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int CMD_W  = 16;
  localparam int IDX_W  = $clog2(CMD_W);
  localparam int CNT_W  = $clog2(CMD_W + 1);
  localparam int OP_W   = 4;
  localparam int ADDR_W = 4;
  localparam int DAT_W  = 8;
  localparam int ST_W   = 2;
  localparam int OP_LSB = CMD_W - OP_W;
  localparam int AD_LSB = DAT_W;

  localparam logic [OP_W-1:0] OP_ECHO = 4'h1;
  localparam logic [OP_W-1:0] OP_STAT = 4'h2;
  localparam logic [OP_W-1:0] OP_WR   = 4'h3;
  localparam logic [OP_W-1:0] OP_RD   = 4'h4;
  localparam logic [OP_W-1:0] OP_CLR  = 4'h5;

  typedef enum logic [1:0] {RX_IDLE, RX_SHIFT, RX_OVER} rx_state_e;
endpackage

// File: rtl/tbp_rx.sv
module tbp_rx
  import tbp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_ni,
  input  logic             mode_i,
  input  logic             sdi_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             scan_o,
  output logic             scan_shift_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             ok_o,
  output logic             par_err_o,
  output logic             frm_err_o
);
  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] sr_q;
  logic             scan_q;
  logic             full, release_c, in_shift, par_good;

  assign in_shift  = (state_q == RX_SHIFT);
  assign full      = (cnt_q == CNT_W'(CMD_W));
  assign release_c = in_shift && sel_ni;
  assign par_good  = (sdi_i == ~^sr_q);

  assign ok_o         = release_c && !scan_q && full && par_good;
  assign par_err_o    = release_c && !scan_q && full && !par_good;
  assign frm_err_o    = !scan_q && ((release_c && !full) || (in_shift && !sel_ni && full));
  assign scan_shift_o = in_shift && !sel_ni && scan_q;

  assign cnt_o  = cnt_q;
  assign scan_o = scan_q;
  assign cmd_o  = sr_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      scan_q  <= 1'b0;
    end else begin
      unique case (state_q)
        RX_IDLE: if (!sel_ni) begin
          state_q <= RX_SHIFT;
          cnt_q   <= '0;
          scan_q  <= mode_i;
        end
        RX_SHIFT: begin
          if (sel_ni) state_q <= RX_IDLE;
          else if (!scan_q) begin
            if (!full) begin
              sr_q  <= {sdi_i, sr_q[CMD_W-1:1]};
              cnt_q <= cnt_q + 1'b1;
            end else state_q <= RX_OVER;
          end
        end
        RX_OVER: if (sel_ni) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  a_r1_cnt_bound: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CMD_W));
  a_r5_ok_vs_frame: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !(ok_o && frm_err_o));
  a_r4_ok_vs_parity: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !(ok_o && par_err_o));
endmodule

// File: rtl/tbp_scan.sv
module tbp_scan #(
  parameter int LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic sdi_i,
  output logic so_o
);
  logic [LEN-1:0] chain_q;

  generate
    if (LEN == 1) begin : g_one
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else if (shift_i) chain_q <= sdi_i;
      end
    end else begin : g_many
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else if (shift_i) chain_q <= {sdi_i, chain_q[LEN-1:1]};
      end
    end
  endgenerate

  assign so_o = chain_q[0];
endmodule

// File: rtl/tbp_exec.sv
module tbp_exec
  import tbp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ok_i,
  input  logic             par_err_i,
  input  logic             frm_err_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [DAT_W-1:0] rdata_i,
  output logic [CMD_W-1:0] resp_o,
  output logic             exec_o,
  output logic             we_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             irq_no
);
  logic [CMD_W-1:0] resp_q, cmd_q, resp_d;
  logic [ST_W-1:0]  status_q;
  logic             exec_q, we_q, clr_c;
  logic [OP_W-1:0]  op;

  assign op    = cmd_i[CMD_W-1:OP_LSB];
  assign clr_c = ok_i && (op == OP_CLR);

  always_comb begin
    unique case (op)
      OP_ECHO, OP_WR, OP_CLR: resp_d = cmd_i;
      OP_STAT: resp_d = CMD_W'(status_q);
      OP_RD:   resp_d = {cmd_i[CMD_W-1:DAT_W], rdata_i};
      default: resp_d = '0;
    endcase
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q   <= '0;
      cmd_q    <= '0;
      status_q <= '0;
      exec_q   <= 1'b0;
      we_q     <= 1'b0;
    end else begin
      exec_q <= ok_i;
      we_q   <= ok_i && (op == OP_WR);
      if (ok_i) begin
        resp_q <= resp_d;
        cmd_q  <= cmd_i;
      end
      if (clr_c) status_q <= '0;
      else       status_q <= status_q | {frm_err_i, par_err_i};
    end
  end

  assign resp_o = resp_q;
  assign exec_o = exec_q;
  assign we_o   = we_q;
  assign cmd_o  = cmd_q;
  assign irq_no = ~|status_q;

  a_r3_exec_single: assert property (@(negedge clk_i) disable iff (!rst_ni)
    exec_q |=> !exec_q);
  a_r4_parity_flags: assert property (@(negedge clk_i) disable iff (!rst_ni)
    par_err_i |=> (status_q[0] && !irq_no));
  a_r4_parity_sticky: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (status_q[0] && !clr_c) |=> status_q[0]);
  a_r4_no_exec_on_err: assert property (@(negedge clk_i) disable iff (!rst_ni)
    par_err_i |=> !exec_q);
  a_r9_we_with_exec: assert property (@(negedge clk_i) disable iff (!rst_ni)
    we_q |-> exec_q);
endmodule

// File: rtl/tbp_port.sv
module tbp_port
  import tbp_pkg::*;
#(
  parameter int SCAN_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              mode_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              irq_no,
  output logic              exec_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DAT_W-1:0]  reg_wdata_o,
  input  logic [DAT_W-1:0]  reg_rdata_i
);
  logic [CNT_W-1:0] cnt;
  logic             scan, scan_shift, ok, par_err, frm_err, scan_so, resp_bit;
  logic [CMD_W-1:0] rx_cmd, resp;

  tbp_rx u_rx (
    .clk_i, .rst_ni, .sel_ni, .mode_i, .sdi_i,
    .cnt_o(cnt), .scan_o(scan), .scan_shift_o(scan_shift), .cmd_o(rx_cmd),
    .ok_o(ok), .par_err_o(par_err), .frm_err_o(frm_err)
  );

  tbp_scan #(.LEN(SCAN_LEN)) u_scan (
    .clk_i, .rst_ni, .shift_i(scan_shift), .sdi_i, .so_o(scan_so)
  );

  tbp_exec u_exec (
    .clk_i, .rst_ni, .ok_i(ok), .par_err_i(par_err), .frm_err_i(frm_err),
    .cmd_i(rx_cmd), .rdata_i(reg_rdata_i), .resp_o(resp), .exec_o,
    .we_o(reg_we_o), .cmd_o, .irq_no
  );

  // response streams by bit index; parity follows the last bit
  assign resp_bit    = (cnt < CNT_W'(CMD_W)) ? resp[cnt[IDX_W-1:0]] : ~^resp;
  assign sdo_o       = scan ? scan_so : resp_bit;
  assign reg_addr_o  = rx_cmd[AD_LSB +: ADDR_W];
  assign reg_wdata_o = rx_cmd[DAT_W-1:0];

  a_r12_scan_quiet: assert property (@(negedge clk_i) disable iff (!rst_ni)
    scan |-> !(ok || par_err || frm_err));
  a_r12_scan_keeps_resp: assert property (@(negedge clk_i) disable iff (!rst_ni)
    scan |=> $stable(resp));
endmodule

// File: tb/tb_tbp_port.sv
`timescale 1ns/1ps
module tb_tbp_port;
  localparam int SL = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel_n = 1'b1, mode = 1'b0, sdi = 1'b0;
  logic        sdo, irq_n, exec, we;
  logic [15:0] cmd;
  logic [3:0]  addr;
  logic [7:0]  wdata, rdata;
  logic [7:0]  rf [16];

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] prev = 16'h0000;
  bit hist [0:255];
  int scan_n = 0;

  always #2 clk = ~clk;

  tbp_port #(.SCAN_LEN(SL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .mode_i(mode), .sdi_i(sdi),
    .sdo_o(sdo), .irq_no(irq_n), .exec_o(exec), .cmd_o(cmd), .reg_we_o(we),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) for (int k = 0; k < 16; k++) rf[k] <= 8'(k * 17);
    else if (we) rf[addr] <= wdata;
  end
  assign rdata = rf[addr];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // full command frame; leaves time just after the parity edge
  task automatic xfer(input logic [15:0] d, input bit bad_par, input bit b2b);
    if (!b2b) @(posedge clk);
    sel_n = 1'b0; mode = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(posedge clk);
      check("R2 sdo data bit", {31'd0, sdo}, {31'd0, prev[i]});
      sdi = d[i];
      @(negedge clk);
    end
    @(posedge clk);
    check("R2 sdo parity", {31'd0, sdo}, {31'd0, ~^prev});
    sel_n = 1'b1; sdi = (~^d) ^ bad_par;
    @(negedge clk);
  endtask

  task automatic partial(input int nbits, input bit scan_m);
    @(posedge clk);
    sel_n = 1'b0; mode = scan_m;
    @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      @(posedge clk);
      if (scan_m) begin
        check("R12 scan delay", {31'd0, sdo},
              {31'd0, (scan_n < SL) ? 1'b0 : hist[scan_n - SL]});
        sdi = ((i * 5 + 3) % 7) < 3;
        hist[scan_n] = sdi;
        scan_n++;
      end else sdi = i[0];
      @(negedge clk);
    end
    @(posedge clk);
    sel_n = 1'b1; mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    check("R2 reset sdo", {31'd0, sdo}, 32'd0);
    check("R6 reset irq", {31'd0, irq_n}, 32'd1);
    check("R3 reset exec", {31'd0, exec}, 32'd0);
  endtask

  task automatic t_echo;
    xfer(16'h1ABC, 0, 0);
    @(posedge clk);
    check("R3 exec pulse", {31'd0, exec}, 32'd1);
    check("R3 cmd_o", {16'd0, cmd}, 32'h1ABC);
    check("R9 no write on echo", {31'd0, we}, 32'd0);
    @(posedge clk);
    check("R3 exec one cycle", {31'd0, exec}, 32'd0);
    prev = 16'h1ABC;
    xfer(16'h1234, 0, 0);             // R7: stream of echo response checked inside
    prev = 16'h1234;
  endtask

  task automatic t_write_read;
    xfer(16'h35A7, 0, 0);
    @(posedge clk);
    check("R9 we pulse", {31'd0, we}, 32'd1);
    check("R9 addr", {28'd0, addr}, 32'h5);
    check("R9 wdata", {24'd0, wdata}, 32'hA7);
    prev = 16'h35A7;
    xfer(16'h4500, 0, 1);             // R13 back-to-back start
    prev = 16'h45A7;
    xfer(16'h1000, 0, 0);             // R10 read response streamed
    prev = 16'h1000;
  endtask

  task automatic t_parity;
    xfer(16'h1F0F, 1, 0);
    @(posedge clk);
    check("R4 no exec on bad parity", {31'd0, exec}, 32'd0);
    check("R4 irq low", {31'd0, irq_n}, 32'd0);
    xfer(16'h2000, 0, 0);             // R4 response kept as previous
    prev = 16'h0001;
    xfer(16'h5000, 0, 0);             // R8 status bit0 streamed
    @(posedge clk);
    check("R11 clear releases irq", {31'd0, irq_n}, 32'd1);
    prev = 16'h5000;
  endtask

  task automatic t_framing;
    partial(8, 0);
    @(posedge clk);
    check("R5 early release no exec", {31'd0, exec}, 32'd0);
    check("R6 irq on framing", {31'd0, irq_n}, 32'd0);
    xfer(16'h2000, 0, 0);
    prev = 16'h0002;
    xfer(16'h5000, 0, 0);             // R5 status bit1 streamed
    prev = 16'h5000;
    partial(17, 0);
    @(posedge clk);
    check("R5 overrun no exec", {31'd0, exec}, 32'd0);
    check("R5 overrun irq", {31'd0, irq_n}, 32'd0);
    xfer(16'h2000, 0, 0);
    prev = 16'h0002;
    xfer(16'h5000, 0, 0);
    prev = 16'h5000;
  endtask

  task automatic t_scan;
    partial(24, 1);
    @(posedge clk);
    check("R12 scan no exec", {31'd0, exec}, 32'd0);
    check("R12 scan status", {31'd0, irq_n}, 32'd1);
    partial(5, 1);
    xfer(16'h9123, 0, 0);             // R12 response unchanged by scan
    @(posedge clk);
    check("R11 unknown opcode exec", {31'd0, exec}, 32'd1);
    prev = 16'h0000;
    xfer(16'h1000, 0, 0);             // R11 unknown opcode gives zero
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    t_reset();
    t_echo();
    t_write_read();
    t_parity();
    t_framing();
    t_scan();
    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule